// File: doc/BRIEF.md
# Region-Based Secure Access Checker

This block decides, one transaction at a time, whether a memory access may go ahead. Every request presents an address, a direction (read or write), a flag telling whether the requester is secure or non-secure, a 4-bit non-secure master identifier, and the index of the filter port it arrived on. The checker compares the address against a set of programmable address windows. It picks the window that governs the access and looks up that window's permissions. One clock later it presents a registered permit or deny decision.

Window 0 is a fixed background that covers every address on every filter; software can change only its permissions. Windows 1 and up are inclusive, 4 KB-granular ranges. Each has its own filter mask, a secure read and write permission, and a read enable and a write enable for each of the 16 non-secure identifiers. When an access is denied, the read data handed back is all zeros and the write strobe toward memory is held low. An error flag is raised as well if the error response has been switched on. Read data from memory is expected in the same cycle as the request and is gated on its way back.

A simple write-only configuration port programs the window registers and the error-response enable.

Top module: `region_access_checker`

## Requirements
- R1: After synchronous reset, dec_valid, dec_permit, dec_err and mem_wr_en are 0 and rd_data_out is zero. Every window has no permissions, so any transaction is denied and reports window 0.
- R2: A transaction sampled with txn_valid high at a rising edge produces its decision on the outputs right after that edge. dec_valid is high exactly in the cycles that follow a cycle with txn_valid high.
- R3: Window 0 matches every address on every filter. Writes to its base, top or filter-mask fields have no effect. Its secure and per-identifier permissions are programmable.
- R4: Window n (n ≥ 1) matches when base ≤ address ≤ top. Address bits 11:0 of a written base are ignored (treated as 0). Bits 11:0 of a written top are ignored and treated as 0xFFF.
- R5: Window n (n ≥ 1) takes part only when bit txn_filter of its attribute bits 3:0 is set.
- R6: When several windows match, the highest-numbered one decides. Window 0 decides only when no other window matches. dec_region reports the deciding window.
- R7: A window whose base lies above its top matches no address.
- R8: For a secure transaction, attribute bit 30 grants read and attribute bit 31 grants write. A clear bit denies.
- R9: For a non-secure transaction with identifier k, identifier-register bit k grants read and bit 16+k grants write. A clear bit denies.
- R10: rd_data_out carries rd_data_in for a permitted read and is zero for any denied access or write.
- R11: mem_wr_en is high only for a permitted write.
- R12: Bit 0 of the control word at offset 0x004 enables the error response. With it set, dec_err is high for every denied transaction; with it clear, dec_err stays 0.
- R13: Window n's words sit at byte offset 0x100 + 0x20·n: +0x00 base low (address bits 31:12 in data bits 31:12), +0x04 base high (address bits above 31), +0x08 top low, +0x0C top high, +0x10 attributes, +0x14 identifier enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | ADDR_W | Transaction byte address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_nonsec | input | 1 | 1 = non-secure requester |
| txn_id | input | ID_W | Non-secure master identifier |
| txn_filter | input | FILT_W | Filter port the transaction came through |
| rd_data_in | input | DATA_W | Read data from memory, aligned with the request |
| dec_valid | output | 1 | Decision valid |
| dec_permit | output | 1 | Access permitted |
| dec_region | output | RGN_W | Index of the deciding window |
| dec_err | output | 1 | Error response for a denied access |
| mem_wr_en | output | 1 | Write strobe toward memory, permitted writes only |
| rd_data_out | output | DATA_W | Read data to requester, zeroed unless permitted |

## Verification
A corrupted base or top page, a stuck filter-mask bit or a wrong priority pick shows up as a wrong dec_region. The decision for the affected address then flips, on the first transaction that touches it, one cycle after that transaction is presented. A permission bit held in the wrong place flips dec_permit, rd_data_out and mem_wr_en together in that same cycle. The stimulus therefore probes both edges of each window, the overlaps between windows, every permission class and the window that can never match. In each case both the deciding window and the gated outputs are compared.

// File: rtl/region_chk_pkg.sv
package region_chk_pkg;
  // Configuration map (byte offsets within the 4 KB configuration frame)
  localparam logic [11:0] CTRL_OFS       = 12'h004;
  localparam logic [11:0] WIN_FIRST_OFS  = 12'h100;
  localparam int          WIN_STRIDE_LG2 = 5;
  localparam int          PAGE_LG2       = 12;
  localparam int          LO_PAGE_W      = 32 - PAGE_LG2;

  // Word select within one window's 0x20-byte slot (byte offset / 4)
  typedef enum logic [2:0] {
    WSEL_BASE_LO = 3'd0,
    WSEL_BASE_HI = 3'd1,
    WSEL_TOP_LO  = 3'd2,
    WSEL_TOP_HI  = 3'd3,
    WSEL_ATTR    = 3'd4,
    WSEL_IDEN    = 3'd5
  } wsel_e;

  localparam int ATTR_SRD_BIT  = 30;
  localparam int ATTR_SWR_BIT  = 31;
  localparam int IDEN_WR_SHIFT = 16;
endpackage

// File: rtl/region_cfg_regs.sv
module region_cfg_regs
  import region_chk_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int NUM_IDS     = 16,
  localparam int PAGE_W     = ADDR_W - PAGE_LG2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    cfg_we,
  input  logic [11:0]                             cfg_addr,
  input  logic [31:0]                             cfg_wdata,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0]      base_pg,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0]      top_pg,
  output logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] fen,
  output logic [NUM_REGIONS-1:0]                  sec_rd,
  output logic [NUM_REGIONS-1:0]                  sec_wr,
  output logic [NUM_REGIONS-1:0][NUM_IDS-1:0]     id_rd,
  output logic [NUM_REGIONS-1:0][NUM_IDS-1:0]     id_wr,
  output logic                                    err_en
);
  localparam int HI_W      = ADDR_W - 32;
  localparam int SPAN      = NUM_REGIONS << WIN_STRIDE_LG2;
  localparam int RSEL_W    = 12 - WIN_STRIDE_LG2;

  logic [11:0]       rel;
  logic              in_win;
  logic [RSEL_W-1:0] rsel;
  wsel_e             wsel;

  assign rel    = cfg_addr - WIN_FIRST_OFS;
  assign in_win = (cfg_addr >= WIN_FIRST_OFS) && (rel < 12'(SPAN));
  assign rsel   = rel[11:WIN_STRIDE_LG2];
  assign wsel   = wsel_e'(rel[4:2]);

  always_ff @(posedge clk) begin
    if (rst)                                err_en <= 1'b0;
    else if (cfg_we && cfg_addr == CTRL_OFS) err_en <= cfg_wdata[0];
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
    logic               hit;
    logic               srd_q, swr_q;
    logic [NUM_IDS-1:0] idr_q, idw_q;

    assign hit = cfg_we && in_win && (rsel == RSEL_W'(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        srd_q <= 1'b0;
        swr_q <= 1'b0;
        idr_q <= '0;
        idw_q <= '0;
      end else if (hit) begin
        if (wsel == WSEL_ATTR) begin
          srd_q <= cfg_wdata[ATTR_SRD_BIT];
          swr_q <= cfg_wdata[ATTR_SWR_BIT];
        end
        if (wsel == WSEL_IDEN) begin
          idr_q <= cfg_wdata[NUM_IDS-1:0];
          idw_q <= cfg_wdata[IDEN_WR_SHIFT +: NUM_IDS];
        end
      end
    end

    assign sec_rd[r] = srd_q;
    assign sec_wr[r] = swr_q;
    assign id_rd[r]  = idr_q;
    assign id_wr[r]  = idw_q;

    if (r == 0) begin : g_background
      // Background window: fixed full range, present on every filter
      assign base_pg[r] = '0;
      assign top_pg[r]  = '1;
      assign fen[r]     = '1;
    end else begin : g_ranged
      logic [PAGE_W-1:0]      base_q, top_q;
      logic [NUM_FILTERS-1:0] fen_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          base_q <= '0;
          top_q  <= '0;
          fen_q  <= '0;
        end else if (hit) begin
          case (wsel)
            WSEL_BASE_LO: base_q[LO_PAGE_W-1:0]      <= cfg_wdata[31:PAGE_LG2];
            WSEL_BASE_HI: base_q[PAGE_W-1:LO_PAGE_W] <= cfg_wdata[HI_W-1:0];
            WSEL_TOP_LO:  top_q[LO_PAGE_W-1:0]       <= cfg_wdata[31:PAGE_LG2];
            WSEL_TOP_HI:  top_q[PAGE_W-1:LO_PAGE_W]  <= cfg_wdata[HI_W-1:0];
            WSEL_ATTR:    fen_q                      <= cfg_wdata[NUM_FILTERS-1:0];
            default: ;
          endcase
        end
      end

      assign base_pg[r] = base_q;
      assign top_pg[r]  = top_q;
      assign fen[r]     = fen_q;
    end
  end
endmodule

// File: rtl/region_matcher.sv
module region_matcher #(
  parameter int PAGE_W      = 28,
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  localparam int FILT_W     = $clog2(NUM_FILTERS)
) (
  input  logic [PAGE_W-1:0]                       addr_pg,
  input  logic [FILT_W-1:0]                       filt_idx,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0]      base_pg,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0]      top_pg,
  input  logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] fen,
  output logic [NUM_REGIONS-1:0]                  match_vec
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    if (r == 0) begin : g_bg
      assign match_vec[r] = 1'b1;
    end else begin : g_rng
      // Inclusive page compare; base page above top page can never satisfy both
      assign match_vec[r] = (addr_pg >= base_pg[r]) && (addr_pg <= top_pg[r])
                            && fen[r][filt_idx];
    end
  end
endmodule

// File: rtl/perm_resolve.sv
module perm_resolve #(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_IDS     = 16,
  localparam int RGN_W      = $clog2(NUM_REGIONS),
  localparam int ID_W       = $clog2(NUM_IDS)
) (
  input  logic [NUM_REGIONS-1:0]              match_vec,
  input  logic [NUM_REGIONS-1:0]              sec_rd,
  input  logic [NUM_REGIONS-1:0]              sec_wr,
  input  logic [NUM_REGIONS-1:0][NUM_IDS-1:0] id_rd,
  input  logic [NUM_REGIONS-1:0][NUM_IDS-1:0] id_wr,
  input  logic                                is_write,
  input  logic                                nonsec,
  input  logic [ID_W-1:0]                     id,
  output logic [RGN_W-1:0]                    win_idx,
  output logic                                permit
);
  always_comb begin
    win_idx = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (match_vec[r]) win_idx = RGN_W'(r);
    end
  end

  always_comb begin
    unique case ({nonsec, is_write})
      2'b00:   permit = sec_rd[win_idx];
      2'b01:   permit = sec_wr[win_idx];
      2'b10:   permit = id_rd[win_idx][id];
      default: permit = id_wr[win_idx][id];
    endcase
  end
endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
  import region_chk_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int NUM_IDS     = 16,
  localparam int PAGE_W     = ADDR_W - PAGE_LG2,
  localparam int RGN_W      = $clog2(NUM_REGIONS),
  localparam int FILT_W     = $clog2(NUM_FILTERS),
  localparam int ID_W       = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_write,
  input  logic              txn_nonsec,
  input  logic [ID_W-1:0]   txn_id,
  input  logic [FILT_W-1:0] txn_filter,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic              dec_valid,
  output logic              dec_permit,
  output logic [RGN_W-1:0]  dec_region,
  output logic              dec_err,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] rd_data_out
);
  logic [NUM_REGIONS-1:0][PAGE_W-1:0]      base_pg, top_pg;
  logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] fen;
  logic [NUM_REGIONS-1:0]                  sec_rd, sec_wr, match_vec;
  logic [NUM_REGIONS-1:0][NUM_IDS-1:0]     id_rd, id_wr;
  logic                                    err_en, permit;
  logic [RGN_W-1:0]                        win_idx;

  region_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
    .NUM_FILTERS(NUM_FILTERS), .NUM_IDS(NUM_IDS)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .base_pg(base_pg), .top_pg(top_pg), .fen(fen), .sec_rd(sec_rd), .sec_wr(sec_wr),
    .id_rd(id_rd), .id_wr(id_wr), .err_en(err_en)
  );

  region_matcher #(
    .PAGE_W(PAGE_W), .NUM_REGIONS(NUM_REGIONS), .NUM_FILTERS(NUM_FILTERS)
  ) u_match (
    .addr_pg(txn_addr[ADDR_W-1:PAGE_LG2]), .filt_idx(txn_filter),
    .base_pg(base_pg), .top_pg(top_pg), .fen(fen), .match_vec(match_vec)
  );

  perm_resolve #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_IDS(NUM_IDS)
  ) u_res (
    .match_vec(match_vec), .sec_rd(sec_rd), .sec_wr(sec_wr), .id_rd(id_rd), .id_wr(id_wr),
    .is_write(txn_write), .nonsec(txn_nonsec), .id(txn_id),
    .win_idx(win_idx), .permit(permit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      dec_permit  <= 1'b0;
      dec_region  <= '0;
      dec_err     <= 1'b0;
      mem_wr_en   <= 1'b0;
      rd_data_out <= '0;
    end else begin
      dec_valid   <= txn_valid;
      dec_permit  <= txn_valid && permit;
      dec_region  <= win_idx;
      dec_err     <= txn_valid && !permit && err_en;
      mem_wr_en   <= txn_valid && txn_write && permit;
      rd_data_out <= (txn_valid && !txn_write && permit) ? rd_data_in : '0;
    end
  end

  // Deciding window matches and no higher-numbered window matches
  AST_WIN_IS_TOP_MATCH: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> ((match_vec >> win_idx) == NUM_REGIONS'(1))); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> dec_valid); // R2
  AST_DENY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_permit) |-> (rd_data_out == '0)); // R10
  AST_WR_ONLY_PERMIT: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (dec_permit && $past(txn_write))); // R11
  AST_ERR_ON_DENY: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (dec_valid && !dec_permit)); // R12
endmodule

// File: tb/region_access_checker_tb.sv
`timescale 1ns/1ps
module region_access_checker_tb;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [11:0]       cfg_addr;
  logic [31:0]       cfg_wdata;
  logic              txn_valid;
  logic [ADDR_W-1:0] txn_addr;
  logic              txn_write, txn_nonsec;
  logic [3:0]        txn_id;
  logic [1:0]        txn_filter;
  logic [DATA_W-1:0] rd_data_in;
  logic              dec_valid, dec_permit, dec_err, mem_wr_en;
  logic [3:0]        dec_region;
  logic [DATA_W-1:0] rd_data_out;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  region_access_checker u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_write(txn_write),
    .txn_nonsec(txn_nonsec), .txn_id(txn_id), .txn_filter(txn_filter),
    .rd_data_in(rd_data_in), .dec_valid(dec_valid), .dec_permit(dec_permit),
    .dec_region(dec_region), .dec_err(dec_err), .mem_wr_en(mem_wr_en),
    .rd_data_out(rd_data_out)
  );

  // {req[3:0], filter[1:0], addr[39:0], write, nonsec, id[3:0], exp_permit, exp_region[3:0]}
  localparam int NV = 23;
  localparam logic [56:0] VEC [NV] = '{
    {4'd3,  2'd0, 40'h00_0000_0100, 1'b0, 1'b0, 4'd0,  1'b1, 4'd0}, // R3 background secure read
    {4'd8,  2'd0, 40'h00_0000_0100, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R8 no secure write
    {4'd9,  2'd0, 40'h00_0000_0100, 1'b0, 1'b1, 4'd2,  1'b1, 4'd0}, // R9 id2 read
    {4'd9,  2'd0, 40'h00_0000_0100, 1'b0, 1'b1, 4'd3,  1'b0, 4'd0}, // R9 id3 read denied
    {4'd4,  2'd0, 40'h00_0001_0000, 1'b1, 1'b0, 4'd0,  1'b1, 4'd1}, // R4 base edge
    {4'd4,  2'd0, 40'h00_0001_FFFF, 1'b0, 1'b1, 4'd3,  1'b1, 4'd1}, // R4 inclusive top
    {4'd4,  2'd0, 40'h00_0002_0000, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R4 past top
    {4'd4,  2'd0, 40'h00_0000_FFFF, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R4 below base
    {4'd6,  2'd0, 40'h00_0001_8800, 1'b1, 1'b0, 4'd0,  1'b0, 4'd2}, // R6 overlap, window 2 wins
    {4'd6,  2'd0, 40'h00_0001_8800, 1'b0, 1'b0, 4'd0,  1'b1, 4'd2}, // R6
    {4'd6,  2'd0, 40'h00_0001_8800, 1'b1, 1'b1, 4'd5,  1'b1, 4'd2}, // R6 id5 write
    {4'd6,  2'd0, 40'h00_0001_8800, 1'b1, 1'b1, 4'd3,  1'b0, 4'd2}, // R6 window 1 would allow
    {4'd5,  2'd1, 40'h00_0001_0000, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R5 window 1 off filter 1
    {4'd5,  2'd1, 40'h00_0001_8000, 1'b0, 1'b0, 4'd0,  1'b1, 4'd2}, // R5 window 2 on filter 1
    {4'd5,  2'd0, 40'h12_0000_0800, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R5 window 3 off filter 0
    {4'd13, 2'd1, 40'h12_0000_0800, 1'b1, 1'b0, 4'd0,  1'b1, 4'd3}, // R13 high address word
    {4'd9,  2'd1, 40'h12_0000_0800, 1'b0, 1'b1, 4'd15, 1'b1, 4'd3}, // R9 id15 read
    {4'd8,  2'd1, 40'h12_0000_0800, 1'b0, 1'b0, 4'd0,  1'b0, 4'd3}, // R8 write-only window
    {4'd7,  2'd2, 40'h00_0000_4FFF, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R7 inverted window
    {4'd7,  2'd2, 40'h00_0000_5000, 1'b0, 1'b0, 4'd0,  1'b1, 4'd0}, // R7 inverted window
    {4'd13, 2'd0, 40'h01_0001_0000, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0}, // R13 high bits differ
    {4'd3,  2'd3, 40'hFF_FFFF_F000, 1'b0, 1'b0, 4'd0,  1'b1, 4'd0}, // R3 top of space, filter 3
    {4'd9,  2'd0, 40'h00_0001_2000, 1'b1, 1'b1, 4'd3,  1'b1, 4'd1}  // R9 id3 write
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic txn(input logic [1:0] f, input logic [39:0] a, input logic w,
                     input logic ns, input logic [3:0] id, input logic [31:0] d);
    @(negedge clk);
    txn_valid = 1'b1; txn_filter = f; txn_addr = a; txn_write = w;
    txn_nonsec = ns; txn_id = id; rd_data_in = d;
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    txn_valid = 1'b0; txn_addr = '0; txn_write = 1'b0; txn_nonsec = 1'b0;
    txn_id = '0; txn_filter = '0; rd_data_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 dec_valid", 64'(dec_valid), 64'd0);
    check("R1 mem_wr_en", 64'(mem_wr_en), 64'd0);
    check("R1 rd_data_out", 64'(rd_data_out), 64'd0);
    txn(2'd0, 40'h0, 1'b0, 1'b0, 4'd0, 32'hDEAD_BEEF);
    check("R1 permit", 64'(dec_permit), 64'd0);
    check("R1 region", 64'(dec_region), 64'd0);
    check("R1 rdata", 64'(rd_data_out), 64'd0);
    check("R2 dec_valid after txn", 64'(dec_valid), 64'd1);

    // Window 0: range writes must be ignored (R3)
    cfg_write(12'h100, 32'h0010_0000);
    cfg_write(12'h108, 32'h0020_0000);
    cfg_write(12'h110, 32'h4000_0000);
    cfg_write(12'h114, 32'h0000_0004);
    // Window 1 (R4 low bits ignored)
    cfg_write(12'h120, 32'h0001_0ABC);
    cfg_write(12'h124, 32'h0);
    cfg_write(12'h128, 32'h0001_F000);
    cfg_write(12'h12C, 32'h0);
    cfg_write(12'h130, 32'hC000_0001);
    cfg_write(12'h134, 32'h0008_0008);
    // Window 2
    cfg_write(12'h140, 32'h0001_8000);
    cfg_write(12'h148, 32'h0001_8000);
    cfg_write(12'h150, 32'h4000_0003);
    cfg_write(12'h154, 32'h0020_0000);
    // Window 3 (high word)
    cfg_write(12'h160, 32'h0);
    cfg_write(12'h164, 32'h12);
    cfg_write(12'h168, 32'h0);
    cfg_write(12'h16C, 32'h12);
    cfg_write(12'h170, 32'h8000_0002);
    cfg_write(12'h174, 32'h8000_8000);
    // Window 4: base above top (R7)
    cfg_write(12'h180, 32'h0000_5000);
    cfg_write(12'h188, 32'h0000_4000);
    cfg_write(12'h190, 32'hC000_000F);
    cfg_write(12'h194, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic        w, ep;
      logic [3:0]  er;
      logic [31:0] d;
      string       tag;
      rq = VEC[i][56:53];
      w  = VEC[i][10];
      ep = VEC[i][4];
      er = VEC[i][3:0];
      d  = 32'hA5A5_0000 | 32'(i);
      tag = $sformatf("R%0d vec%0d", rq, i);
      txn(VEC[i][52:51], VEC[i][50:11], w, VEC[i][9], VEC[i][8:5], d);
      check({tag, " permit"}, 64'(dec_permit), 64'(ep));
      check({tag, " region"}, 64'(dec_region), 64'(er));
      check({tag, " R10 rdata"}, 64'(rd_data_out), 64'((ep && !w) ? d : 32'h0));
      check({tag, " R11 wr_en"}, 64'(mem_wr_en), 64'(ep && w));
      check({tag, " R12 err off"}, 64'(dec_err), 64'd0);
    end

    // R2: idle cycle yields no decision
    @(negedge clk);
    check("R2 idle dec_valid", 64'(dec_valid), 64'd0);
    check("R11 idle wr_en", 64'(mem_wr_en), 64'd0);

    // R12: error response enabled
    cfg_write(12'h004, 32'h1);
    txn(2'd0, 40'h100, 1'b1, 1'b0, 4'd0, 32'h1234_5678);
    check("R12 err on deny", 64'(dec_err), 64'd1);
    check("R12 deny permit", 64'(dec_permit), 64'd0);
    txn(2'd0, 40'h100, 1'b0, 1'b0, 4'd0, 32'h1234_5678);
    check("R12 no err on permit", 64'(dec_err), 64'd0);
    check("R10 permitted read data", 64'(rd_data_out), 64'h1234_5678);

    // R13: window 1 attributes rewritten through its offset revoke access
    cfg_write(12'h130, 32'h0000_0001);
    txn(2'd0, 40'h00_0001_0000, 1'b1, 1'b0, 4'd0, 32'h0);
    check("R13 attr rewrite permit", 64'(dec_permit), 64'd0);
    check("R13 attr rewrite region", 64'(dec_region), 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule